// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block sequences the cycles of a processor-style external bus that can overlap the address of the next cycle with the data phase of the current one. It watches four active-high inputs: an internal request-pending flag, a next-address hint from the target, a ready signal that ends the data phase, and a hold request from another bus master. It drives an address strobe, an address-load enable for the address register, a hold acknowledge, and its current state.

Seven states are tracked. IDLE waits for work. HOLD_ACK has given the bus away. ADDR is the first clock of a non-overlapped cycle, and ADDR_PIPE is the first clock of a cycle whose address went out early. DATA is a data clock before the next-address hint has been seen. DATA_NA is a data clock after the hint with no new request waiting. DATA_NP is a data clock after the hint with a request waiting, whose address has already been issued. Transitions: IDLE/HOLD_ACK to ADDR or HOLD_ACK; ADDR to DATA; DATA and ADDR_PIPE to ADDR, HOLD_ACK or IDLE on completion, or to DATA_NP, DATA_NA or DATA while waiting; DATA_NA to IDLE, HOLD_ACK or DATA_NP; DATA_NP to ADDR_PIPE.

Top module: `bus_cycle_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the state is IDLE and ads, addr_ld and hlda are low.
- R2: In IDLE or HOLD_ACK, hold high leads to HOLD_ACK; else req_pend high leads to ADDR; else the next state is IDLE.
- R3: ADDR always moves to DATA after one clock, and ads and addr_ld are high during every ADDR clock.
- R4: In DATA with ready high, the next state is HOLD_ACK if hold is high, else ADDR if req_pend is high, else IDLE.
- R5: In DATA with ready low, na high leads to DATA_NP if req_pend is high and hold is low, otherwise to DATA_NA; na low keeps DATA.
- R6: In DATA_NA, ready high leads to HOLD_ACK if hold is high, else IDLE; with ready low, req_pend high and hold low lead to DATA_NP, otherwise DATA_NA is kept.
- R7: DATA_NP holds while ready is low and moves to ADDR_PIPE when ready is high; ads and addr_ld are high in the first DATA_NP clock only.
- R8: ADDR_PIPE follows the same rules as DATA (R4 and R5).
- R9: hlda is high exactly when the state is HOLD_ACK; ads and addr_ld are low in every state other than ADDR and the first DATA_NP clock.
- R10: bus_state encodes IDLE=0, HOLD_ACK=1, ADDR=2, DATA=3, DATA_NA=4, DATA_NP=5, ADDR_PIPE=6; code 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend | input | 1 | Internal bus request waiting |
| na | input | 1 | Next-address hint, active high |
| ready | input | 1 | Ends the current data phase, active high |
| hold | input | 1 | Bus hold request, active high |
| ads | output | 1 | Address strobe pulse |
| addr_ld | output | 1 | Load enable for the address register |
| hlda | output | 1 | Hold acknowledge |
| bus_state | output | ST_W | Current state code |

## Verification
The bench builds the block with its default three-bit state code, so every one of the seven legal codes and the unused eighth are visible at bus_state and compared each clock. Random input mixes with biased ready and na drive the sequencer through long waits in each data state, while directed runs produce back-to-back overlapped cycles, a hold arriving mid-cycle and a next-address hint with no request behind it.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        S_IDLE      = 3'd0,
        S_HOLD_ACK  = 3'd1,
        S_ADDR      = 3'd2,
        S_DATA      = 3'd3,
        S_DATA_NA   = 3'd4,
        S_DATA_NP   = 3'd5,
        S_ADDR_PIPE = 3'd6
    } bus_st_e;
endpackage

// File: rtl/bus_cycle_next.sv
module bus_cycle_next
    import bus_cycle_pkg::*;
(
    input  bus_st_e cur,
    input  logic    req_pend,
    input  logic    na,
    input  logic    ready,
    input  logic    hold,
    output bus_st_e nxt
);
    logic launch;
    bus_st_e finish_st;
    bus_st_e wait_st;

    // A new cycle may start only when no hold is requested.
    assign launch = req_pend && !hold;

    // Completion target shared by DATA and ADDR_PIPE.
    always_comb begin
        if (hold)          finish_st = S_HOLD_ACK;
        else if (req_pend) finish_st = S_ADDR;
        else               finish_st = S_IDLE;
    end

    // Wait target shared by DATA and ADDR_PIPE.
    always_comb begin
        if (!na)         wait_st = S_DATA;
        else if (launch) wait_st = S_DATA_NP;
        else             wait_st = S_DATA_NA;
    end

    always_comb begin
        nxt = S_IDLE;
        unique case (cur)
            S_IDLE, S_HOLD_ACK: begin
                if (hold)        nxt = S_HOLD_ACK;
                else if (launch) nxt = S_ADDR;
                else             nxt = S_IDLE;
            end
            S_ADDR:
                nxt = S_DATA;
            S_DATA, S_ADDR_PIPE:
                nxt = ready ? finish_st : wait_st;
            S_DATA_NA: begin
                if (ready)       nxt = hold ? S_HOLD_ACK : S_IDLE;
                else if (launch) nxt = S_DATA_NP;
                else             nxt = S_DATA_NA;
            end
            S_DATA_NP:
                nxt = ready ? S_ADDR_PIPE : S_DATA_NP;
            default:
                nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/bus_cycle_out.sv
module bus_cycle_out
    import bus_cycle_pkg::*;
(
    input  bus_st_e cur,
    input  logic    np_seen,
    output logic    ads,
    output logic    addr_ld,
    output logic    hlda
);
    always_comb begin
        ads  = 1'b0;
        hlda = 1'b0;
        unique case (cur)
            S_ADDR:     ads  = 1'b1;
            S_DATA_NP:  ads  = !np_seen;
            S_HOLD_ACK: hlda = 1'b1;
            default: begin
                ads  = 1'b0;
                hlda = 1'b0;
            end
        endcase
    end

    assign addr_ld = ads;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_cycle_pkg::*;
#(
    parameter int ST_OUT_W = ST_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_pend,
    input  logic                na,
    input  logic                ready,
    input  logic                hold,
    output logic                ads,
    output logic                addr_ld,
    output logic                hlda,
    output logic [ST_OUT_W-1:0] bus_state
);
    bus_st_e st_q;
    bus_st_e st_d;
    logic    np_seen_q;

    bus_cycle_next u_next (
        .cur      (st_q),
        .req_pend (req_pend),
        .na       (na),
        .ready    (ready),
        .hold     (hold),
        .nxt      (st_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            np_seen_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            np_seen_q <= (st_q == S_DATA_NP);
        end
    end

    bus_cycle_out u_out (
        .cur     (st_q),
        .np_seen (np_seen_q),
        .ads     (ads),
        .addr_ld (addr_ld),
        .hlda    (hlda)
    );

    assign bus_state = ST_OUT_W'(st_q);
endmodule

// File: rtl/bus_cycle_chk.sv
module bus_cycle_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_pend,
    input logic       na,
    input logic       ready,
    input logic       hold,
    input logic       ads,
    input logic       addr_ld,
    input logic       hlda,
    input logic [2:0] bus_state
);
    a_r3_addr_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == 3'd2 |=> bus_state == 3'd3);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd0 && hold) |=> bus_state == 3'd1);
    a_r7_np_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd5 && !ready) |=> bus_state == 3'd5);
    a_r7_np_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd5 && ready) |=> bus_state == 3'd6);
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == 3'd5 |=> !(bus_state == 3'd5 && ads));
    a_r9_hlda_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> bus_state == 3'd1);
    a_r9_ld_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld == ads);
    a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state != 3'd7);
endmodule

bind bus_cycle_seq bus_cycle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pend  (req_pend),
    .na        (na),
    .ready     (ready),
    .hold      (hold),
    .ads       (ads),
    .addr_ld   (addr_ld),
    .hlda      (hlda),
    .bus_state (bus_state)
);

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_pend = 1'b0, na = 1'b0, ready = 1'b0, hold = 1'b0;
    logic ads, addr_ld, hlda;
    logic [2:0] bus_state;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_st = 3'd0;
    logic       exp_ads = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .na(na),
        .ready(ready), .hold(hold), .ads(ads), .addr_ld(addr_ld),
        .hlda(hlda), .bus_state(bus_state)
    );

    function automatic logic [2:0] ref_next(input logic [2:0] s,
            input logic rq, input logic n, input logic rd, input logic h);
        logic [2:0] r;
        case (s)
            3'd0, 3'd1: r = h ? 3'd1 : (rq ? 3'd2 : 3'd0);
            3'd2:       r = 3'd3;
            3'd3, 3'd6: begin
                if (rd)      r = h ? 3'd1 : (rq ? 3'd2 : 3'd0);
                else if (!n) r = 3'd3;
                else         r = (rq && !h) ? 3'd5 : 3'd4;
            end
            3'd4: begin
                if (rd) r = h ? 3'd1 : 3'd0;
                else    r = (rq && !h) ? 3'd5 : 3'd4;
            end
            3'd5:    r = rd ? 3'd6 : 3'd5;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3:       return "R4/R5";
            3'd4:       return "R6";
            3'd5:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic cmp(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    string last_tag = "R1";

    task automatic check_outputs();
        cmp({last_tag, " R10 state"}, bus_state, exp_st);
        cmp((exp_st == 3'd5) ? "R7 ads" : "R3 R9 ads", {2'b0, ads}, {2'b0, exp_ads});
        cmp("R9 addr_ld", {2'b0, addr_ld}, {2'b0, exp_ads});
        cmp("R9 hlda", {2'b0, hlda}, {2'b0, exp_st == 3'd1});
    endtask

    // Called at a negedge: check, drive, then advance the model across the posedge.
    task automatic step(input logic rq, input logic n, input logic rd, input logic h);
        logic [2:0] nx;
        check_outputs();
        req_pend = rq; na = n; ready = rd; hold = h;
        nx = ref_next(exp_st, rq, n, rd, h);
        last_tag = tag_of(exp_st);
        exp_ads = (nx == 3'd2) || (nx == 3'd5 && exp_st != 3'd5);
        exp_st = nx;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: in reset
        cmp("R1 reset state", bus_state, 3'd0);
        cmp("R1 reset ads", {2'b0, ads}, 3'd0);
        cmp("R1 reset hlda", {2'b0, hlda}, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Back-to-back overlapped cycles with multi-clock waits
        step(1, 0, 0, 0);             // IDLE -> ADDR
        step(1, 0, 0, 0);             // ADDR -> DATA
        step(1, 0, 0, 0);             // DATA wait
        step(1, 1, 0, 0);             // DATA -> DATA_NP
        step(1, 1, 0, 0);             // DATA_NP wait, no second strobe
        step(1, 1, 0, 0);
        step(1, 1, 1, 0);             // -> ADDR_PIPE
        step(1, 1, 0, 0);             // ADDR_PIPE -> DATA_NP
        step(0, 0, 1, 0);             // -> ADDR_PIPE
        // NA with no request, waits in DATA_NA
        step(0, 1, 0, 0);             // ADDR_PIPE -> DATA_NA
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);             // request appears -> DATA_NP
        step(0, 0, 1, 0);             // -> ADDR_PIPE
        step(0, 0, 0, 0);             // -> DATA
        // Hold mid-cycle
        step(1, 1, 0, 1);             // DATA -> DATA_NA (hold blocks)
        step(1, 0, 0, 1);             // DATA_NA wait
        step(1, 0, 1, 1);             // -> HOLD_ACK
        step(1, 0, 0, 1);             // stay
        step(1, 0, 0, 0);             // -> ADDR
        step(0, 0, 0, 0);             // -> DATA
        step(1, 0, 1, 1);             // DATA complete with hold -> HOLD_ACK
        step(0, 0, 0, 0);             // -> IDLE
        step(0, 0, 0, 1);             // IDLE hold -> HOLD_ACK
        step(0, 0, 0, 0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            step($urandom % 4 != 0, $urandom % 3 == 0, $urandom % 3 == 0, $urandom % 6 == 0);
        end
        check_outputs();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule